// File: doc/BRIEF.md
# Errored-Second and One-Second Interrupt Generator

This block sits in the receive path of a framed line interface and watches eight alarm and error event lines. A one-second interval is counted in cycles of the receive clock. Each event line has its own enable bit. If any enabled event is seen during an interval, the errored-second status bit is set when that interval ends. Every interval end also sets a second status bit, the one-second service flag. Software uses that flag as its cue to read the alarm state and the error counters.

Both status bits are sticky. Software clears each one with its own write-one-to-clear strobe. A single interrupt line is high while either bit is set. All pins are plain control and status signals, so there is no valid/ready handshake and no back-pressure. Event lines are sampled on every receive-clock edge. An event may be a one-cycle pulse or a level that stays high.

Top module: `es_monitor`

## Requirements
- R1: While reset is held, and after reset until the first interval ends, `es_sts_o`, `sec_sts_o` and `irq_o` are 0.
- R2: The interval is SEC_DIV receive-clock cycles long, and the first one starts at reset release. `sec_sts_o` is 0 after SEC_DIV-1 edges and is set by the SEC_DIV-th edge. After that it is set again every SEC_DIV edges.
- R3: An event on `evt_i[b]` while `evt_en_i[b]`=1 sets `es_sts_o` at the end of the interval in which it was sampled. `es_sts_o` is never set before that interval ends. Bit assignment: 0 loss of signal, 1 loss of frame alignment, 2 alarm indication signal, 3 framing bit error, 4 CRC error, 5 code violation, 6 receive slip, 7 transmit slip.
- R4: An event on `evt_i[b]` while `evt_en_i[b]`=0 has no effect on `es_sts_o`.
- R5: `es_sts_o` is evaluated once per interval. An interval with no enabled event leaves a cleared `es_sts_o` at 0, even if the interval before it was errored.
- R6: `sts_clr_i[0]`=1 clears `es_sts_o` and `sts_clr_i[1]`=1 clears `sec_sts_o` on the next edge. Each strobe leaves the other bit unchanged.
- R7: If a clear strobe and a set happen on the same edge, the bit is set.
- R8: `irq_o` is 1 exactly when `es_sts_o` or `sec_sts_o` is 1.
- R9: An event sampled in the last cycle of an interval counts toward that interval. An event sampled in the first cycle of the next interval counts only toward that next interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive line clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| evt_i | input | 8 | Alarm and error event lines (bit map in R3) |
| evt_en_i | input | 8 | Per-event enable for errored-second detection, 1 = enabled |
| sts_clr_i | input | 2 | Write-one-to-clear strobe: bit 0 errored-second, bit 1 one-second |
| es_sts_o | output | 1 | Sticky errored-second status |
| sec_sts_o | output | 1 | Sticky one-second service status |
| irq_o | output | 1 | Interrupt, OR of the two status bits |

## Verification
The hardest cases to reach from the ports are the edges of an interval. These are an event in its very last cycle, an event in the first cycle after it, and a clear strobe on the same edge that ends the interval. The ports give no direct view of the interval phase. The bench therefore builds a short interval and keeps its own phase count from reset release, and it checks that count against the rise of `sec_sts_o`. Each stimulus is then placed on an exact cycle offset of that phase.

// File: rtl/es_mon_pkg.sv
package es_mon_pkg;
  localparam int unsigned N_EVT = 8;

  typedef enum int unsigned {
    EV_LOS   = 0,
    EV_LOFA  = 1,
    EV_AIS   = 2,
    EV_FBIT  = 3,
    EV_CRC   = 4,
    EV_CV    = 5,
    EV_RSLIP = 6,
    EV_XSLIP = 7
  } evt_idx_e;

  typedef struct packed {
    logic sec;
    logic es;
  } sts_t;

  localparam int unsigned N_STS = $bits(sts_t);
endpackage

// File: rtl/es_sec_timer.sv
module es_sec_timer #(
  parameter int unsigned SEC_DIV = 1544000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (SEC_DIV > 2) ? $clog2(SEC_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(SEC_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  // R2
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/es_evt_accum.sv
module es_evt_accum #(
  parameter int unsigned N_EVT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] evt_i,
  input  logic [N_EVT-1:0] evt_en_i,
  input  logic             tick_i,
  output logic             ival_hit_o
);
  logic [N_EVT-1:0] qual;
  logic             cur_hit;
  logic             hit_q;

  for (genvar b = 0; b < N_EVT; b++) begin : g_qual
    assign qual[b] = evt_i[b] & evt_en_i[b];
  end

  assign cur_hit    = |qual;
  // an event in the closing cycle still belongs to the closing interval
  assign ival_hit_o = hit_q | cur_hit;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     hit_q <= 1'b0;
    else if (tick_i) hit_q <= 1'b0;
    else             hit_q <= ival_hit_o;
  end

  // R4
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !hit_q && ((evt_i & evt_en_i) == '0)) |=> !hit_q);

  // R5
  fresh_interval_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (hit_q == 1'b0));
endmodule

// File: rtl/es_sts_reg.sv
module es_sts_reg
  import es_mon_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  sts_t set_i,
  input  sts_t clr_i,
  output sts_t sts_o
);
  logic [N_STS-1:0] set_v, clr_v, sts_q;

  assign set_v = set_i;
  assign clr_v = clr_i;

  for (genvar b = 0; b < N_STS; b++) begin : g_bit
    always_ff @(posedge clk_i) begin
      if (!rst_ni)       sts_q[b] <= 1'b0;
      else if (set_v[b]) sts_q[b] <= 1'b1;
      else if (clr_v[b]) sts_q[b] <= 1'b0;
    end

    // R7
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_v[b] |=> sts_q[b]);

    // R6
    clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_v[b] && !set_v[b]) |=> !sts_q[b]);

    // R3
    rise_on_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sts_q[b] && !set_v[b]) |=> !sts_q[b]);
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/es_monitor.sv
module es_monitor
  import es_mon_pkg::*;
#(
  parameter int unsigned SEC_DIV = 1544000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] evt_i,
  input  logic [N_EVT-1:0] evt_en_i,
  input  logic [1:0]       sts_clr_i,
  output logic             es_sts_o,
  output logic             sec_sts_o,
  output logic             irq_o
);
  logic tick;
  logic ival_hit;
  sts_t set_s, clr_s, sts_s;

  es_sec_timer #(.SEC_DIV(SEC_DIV)) timer_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  es_evt_accum #(.N_EVT(N_EVT)) accum_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt_i),
    .evt_en_i   (evt_en_i),
    .tick_i     (tick),
    .ival_hit_o (ival_hit)
  );

  assign set_s.es  = tick & ival_hit;
  assign set_s.sec = tick;
  assign clr_s.es  = sts_clr_i[0];
  assign clr_s.sec = sts_clr_i[1];

  es_sts_reg sts_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_s),
    .clr_i  (clr_s),
    .sts_o  (sts_s)
  );

  assign es_sts_o  = sts_s.es;
  assign sec_sts_o = sts_s.sec;
  assign irq_o     = sts_s.es | sts_s.sec;

  // R3
  es_only_at_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(es_sts_o) |-> $past(tick));

  // R2
  sec_at_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> sec_sts_o);

  // R8
  irq_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!es_sts_o && !sec_sts_o) |-> !irq_o);
endmodule

// File: tb/es_monitor_tb_top.sv
module es_monitor_tb_top;
  localparam int unsigned DIV = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt = '0;
  logic [7:0] evt_en = '0;
  logic [1:0] clr = '0;
  logic       es_sts, sec_sts, irq;

  int checks = 0;
  int fails = 0;
  int pos = 0;

  always #4 clk = ~clk;

  es_monitor #(.SEC_DIV(DIV)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .evt_i     (evt),
    .evt_en_i  (evt_en),
    .sts_clr_i (clr),
    .es_sts_o  (es_sts),
    .sec_sts_o (sec_sts),
    .irq_o     (irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b pos=%0d t=%0t", req, act, exp, pos, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    pos = (pos + 1) % DIV;
  endtask

  task automatic goto(input int p);
    step();
    while (pos != p) step();
  endtask

  // at pos 0: drop both flags, leaves bench at pos 1
  task automatic clear_all();
    clr = 2'b11;
    step();
    clr = 2'b00;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 es in reset", es_sts, 1'b0);
    chk("R1 irq in reset", irq, 1'b0);
    rst_n = 1'b1;
    pos = 0;
    goto(DIV - 1);
    chk("R1 sec before first end", sec_sts, 1'b0);
    chk("R1 irq before first end", irq, 1'b0);
    step();
    chk("R2 sec at first end", sec_sts, 1'b1);
    chk("R1 es no event", es_sts, 1'b0);
  endtask

  task automatic t_period();
    clear_all();
    chk("R6 sec cleared", sec_sts, 1'b0);
    chk("R8 irq idle", irq, 1'b0);
    goto(DIV - 1);
    chk("R2 sec not early", sec_sts, 1'b0);
    goto(0);
    chk("R2 sec periodic", sec_sts, 1'b1);
  endtask

  task automatic t_enabled();
    clear_all();
    evt_en = 8'hFF;
    evt = 8'b0000_0100;
    step();
    evt = '0;
    goto(DIV - 1);
    chk("R3 es not before end", es_sts, 1'b0);
    goto(0);
    chk("R3 es at end", es_sts, 1'b1);
    clr = 2'b10;
    step();
    clr = 2'b00;
    chk("R6 sec clear keeps es", es_sts, 1'b1);
    chk("R8 irq from es only", irq, 1'b1);
    clr = 2'b01;
    step();
    clr = 2'b00;
    chk("R6 es cleared", es_sts, 1'b0);
    chk("R8 irq low", irq, 1'b0);
  endtask

  task automatic t_masked();
    goto(0);
    clear_all();
    evt_en = 8'hFF & ~8'b0000_1000;
    evt = 8'b0000_1000;
    goto(DIV - 1);
    evt = '0;
    goto(0);
    chk("R4 masked event ignored", es_sts, 1'b0);
    chk("R4 sec still set", sec_sts, 1'b1);
  endtask

  task automatic t_quiet_after_err();
    evt_en = 8'hFF;
    clear_all();
    evt = 8'b1000_0000;
    step();
    evt = '0;
    goto(0);
    chk("R5 errored interval", es_sts, 1'b1);
    clear_all();
    goto(0);
    chk("R5 quiet interval stays clear", es_sts, 1'b0);
  endtask

  task automatic t_same_edge();
    clear_all();
    evt = 8'b0000_0001;
    step();
    evt = '0;
    goto(DIV - 1);
    clr = 2'b11;
    step();
    clr = 2'b00;
    chk("R7 es set wins", es_sts, 1'b1);
    chk("R7 sec set wins", sec_sts, 1'b1);
  endtask

  task automatic t_boundary();
    clear_all();
    goto(DIV - 1);
    evt = 8'b0010_0000;
    step();
    evt = 8'b0100_0000;
    chk("R9 last-cycle event counts", es_sts, 1'b1);
    clr = 2'b11;
    step();
    evt = '0;
    clr = 2'b00;
    chk("R9 es cleared after end", es_sts, 1'b0);
    goto(DIV - 1);
    chk("R9 next interval not early", es_sts, 1'b0);
    goto(0);
    chk("R9 first-cycle event in next interval", es_sts, 1'b1);
  endtask

  initial begin
    t_reset();
    t_period();
    t_enabled();
    t_masked();
    t_quiet_after_err();
    t_same_edge();
    t_boundary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule